// File: doc/BRIEF.md
# Cache-Miss-Driven Resize Controller

This controller watches the memory side of an out-of-order core and picks, every cycle, how large four back-end structures should be: the issue/wakeup width, the reorder buffer, the integer register file and the floating-point register file. Two events count as a long-latency stall. One is a pending second-level cache miss. The other is a pending count of first-level data misses that has reached a threshold. During such a stall the controller halves the issue width (second-level miss only) and enlarges the reorder buffer. A workload-class flag marks the workload as integer or floating point. The register file of the class not in use is kept at half size at all times. The register file of the active class follows the reorder buffer.

When every stall condition has cleared, the controller asks all four structures to return to baseline. It then holds that request until each structure has acknowledged, and only after that does it accept another stall. All inputs are registered first, so each mode output changes only at a clock edge. The controller only decides sizes. The structures carry out the resizing themselves.

Top module: `miss_resize_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, issue, reorder-buffer and integer-file modes are baseline, the floating-point file mode is half, and the restore request is low.
- R2: A pending second-level miss is seen on the issue mode (half) two rising edges after it is driven, unless a restore is in progress.
- R3: A first-level miss count at or above L1_THRESH (default 3) enlarges the reorder buffer two edges later with the issue width left at baseline. A count of L1_THRESH-1 triggers nothing.
- R4: When both stall conditions hold together, the second-level configuration wins: issue half, reorder buffer enlarged.
- R5: The register file of the inactive class is half size whenever the registered class flag selects the other class (flag 1 = floating point, so the integer file is half; flag 0 = integer, so the floating-point file is half).
- R6: The register file of the active class has the same mode as the reorder buffer in every cycle.
- R7: When a stall mode ends with neither condition holding, restore_req_o rises, and issue and reorder-buffer modes go to baseline. A change between the two stall modes goes directly, with no restore.
- R8: The restore request stays high until each of the four done bits has been seen high at least once during the restore, in any order and at any time. Bit 0 is issue, 1 is reorder buffer, 2 is the integer file, 3 is the floating-point file. Miss inputs are ignored during the restore, and done bits outside a restore have no effect.
- R9: Mode encoding is 2'b00 baseline, 2'b01 half, 2'b10 enlarged. The value 2'b11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| l2_miss_i | input | 1 | Second-level miss outstanding |
| l1_miss_cnt_i | input | CNT_W | Pending first-level data misses |
| fp_class_i | input | 1 | 1 = floating-point workload, 0 = integer |
| done_i | input | 4 | Per-structure return-to-baseline acknowledge |
| issue_mode_o | output | 2 | Issue/wakeup width mode |
| rob_mode_o | output | 2 | Reorder buffer mode |
| irf_mode_o | output | 2 | Integer register file mode |
| frf_mode_o | output | 2 | Floating-point register file mode |
| restore_req_o | output | 1 | Return-to-baseline request |

## Verification
The bench uses the defaults CNT_W=4 and L1_THRESH=3. Random miss counts in 0..5 therefore fall on both sides of the threshold, and the directed cases can step exactly from 2 to 3. The four done bits are random and sparse, so restores end after mixed orders and waits of varying length. A directed case also raises a second-level miss during a restore to show that it is ignored.

// File: rtl/rsz_pkg.sv
package rsz_pkg;

  typedef enum logic [1:0] {
    SZ_BASE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_GROW = 2'b10
  } size_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_L2      = 2'd1,
    ST_L1      = 2'd2,
    ST_RESTORE = 2'd3
  } ctl_state_e;

  localparam int unsigned ACK_N = 4;

  function automatic size_mode_e issue_mode_of(ctl_state_e s);
    return (s == ST_L2) ? SZ_HALF : SZ_BASE;
  endfunction

  function automatic size_mode_e rob_mode_of(ctl_state_e s);
    return (s == ST_L2 || s == ST_L1) ? SZ_GROW : SZ_BASE;
  endfunction

  // Active-class file tracks the reorder buffer; the other one is halved.
  function automatic size_mode_e rf_mode_of(ctl_state_e s, logic is_active);
    return is_active ? rob_mode_of(s) : SZ_HALF;
  endfunction

  function automatic ctl_state_e next_state(ctl_state_e s, logic l2, logic l1, logic all_done);
    ctl_state_e n;
    n = s;
    unique case (s)
      ST_IDLE:    if (l2) n = ST_L2; else if (l1) n = ST_L1;
      ST_L2:      if (!l2) n = l1 ? ST_L1 : ST_RESTORE;
      ST_L1:      if (l2) n = ST_L2; else if (!l1) n = ST_RESTORE;
      ST_RESTORE: if (all_done) n = ST_IDLE;
      default:    n = ST_IDLE;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/rsz_in_stage.sv
module rsz_in_stage #(
  parameter int unsigned CNT_W     = 4,
  parameter int unsigned L1_THRESH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             l2_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             fp_i,
  output logic             l2_trig_o,
  output logic             l1_trig_o,
  output logic             fp_q_o
);
  localparam logic [CNT_W-1:0] THR = CNT_W'(L1_THRESH);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l2_trig_o <= 1'b0;
      cnt_q     <= '0;
      fp_q_o    <= 1'b0;
    end else begin
      l2_trig_o <= l2_i;
      cnt_q     <= cnt_i;
      fp_q_o    <= fp_i;
    end
  end

  assign l1_trig_o = (cnt_q >= THR);
endmodule

// File: rtl/rsz_ack_track.sv
module rsz_ack_track #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active_i,
  input  logic [N-1:0] done_i,
  output logic         all_done_o
);
  logic [N-1:0] seen_q;
  logic [N-1:0] got;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         seen_q[g] <= 1'b0;
      else if (!active_i) seen_q[g] <= 1'b0;
      else                seen_q[g] <= seen_q[g] | done_i[g];
    end
    assign got[g] = seen_q[g] | done_i[g];
  end

  assign all_done_o = active_i & (&got);
endmodule

// File: rtl/miss_resize_ctrl.sv
module miss_resize_ctrl
  import rsz_pkg::*;
#(
  parameter int unsigned CNT_W     = 4,
  parameter int unsigned L1_THRESH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             l2_miss_i,
  input  logic [CNT_W-1:0] l1_miss_cnt_i,
  input  logic             fp_class_i,
  input  logic [3:0]       done_i,
  output logic [1:0]       issue_mode_o,
  output logic [1:0]       rob_mode_o,
  output logic [1:0]       irf_mode_o,
  output logic [1:0]       frf_mode_o,
  output logic             restore_req_o
);
  logic       l2_trig, l1_trig, fp_q, all_done, restoring;
  ctl_state_e state_q, state_d;

  rsz_in_stage #(.CNT_W(CNT_W), .L1_THRESH(L1_THRESH)) u_in (
    .clk(clk), .rst_n(rst_n), .l2_i(l2_miss_i), .cnt_i(l1_miss_cnt_i),
    .fp_i(fp_class_i), .l2_trig_o(l2_trig), .l1_trig_o(l1_trig), .fp_q_o(fp_q)
  );

  assign restoring = (state_q == ST_RESTORE);

  rsz_ack_track #(.N(ACK_N)) u_ack (
    .clk(clk), .rst_n(rst_n), .active_i(restoring), .done_i(done_i),
    .all_done_o(all_done)
  );

  assign state_d = next_state(state_q, l2_trig, l1_trig, all_done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign issue_mode_o  = issue_mode_of(state_q);
  assign rob_mode_o    = rob_mode_of(state_q);
  assign irf_mode_o    = rf_mode_of(state_q, !fp_q);
  assign frf_mode_o    = rf_mode_of(state_q, fp_q);
  assign restore_req_o = restoring;
endmodule

// File: rtl/rsz_chk.sv
module rsz_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       l2_trig,
  input logic       l1_trig,
  input logic       fp_q,
  input logic       all_done,
  input logic [1:0] issue_mode_o,
  input logic [1:0] rob_mode_o,
  input logic [1:0] irf_mode_o,
  input logic [1:0] frf_mode_o,
  input logic       restore_req_o
);
  p_issue_half_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (l2_trig && !restore_req_o) |=> (issue_mode_o == 2'b01));

  p_rob_grow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (l1_trig && !restore_req_o) |=> (rob_mode_o == 2'b10));

  p_off_rf_half_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fp_q ? (irf_mode_o == 2'b01) : (frf_mode_o == 2'b01));

  p_active_rf_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fp_q ? (frf_mode_o == rob_mode_o) : (irf_mode_o == rob_mode_o));

  p_restore_base_r7: assert property (@(posedge clk) disable iff (!rst_n)
    restore_req_o |-> (issue_mode_o == 2'b00 && rob_mode_o == 2'b00));

  p_restore_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_req_o && !all_done) |=> restore_req_o);

  p_legal_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_mode_o != 2'b11) && (rob_mode_o != 2'b11) &&
    (irf_mode_o != 2'b11) && (frf_mode_o != 2'b11));
endmodule

bind miss_resize_ctrl rsz_chk u_chk (
  .clk(clk), .rst_n(rst_n), .l2_trig(l2_trig), .l1_trig(l1_trig), .fp_q(fp_q),
  .all_done(all_done), .issue_mode_o(issue_mode_o), .rob_mode_o(rob_mode_o),
  .irf_mode_o(irf_mode_o), .frf_mode_o(frf_mode_o), .restore_req_o(restore_req_o)
);

// File: tb/tb_miss_resize_ctrl.sv
`timescale 1ns/1ps
module tb_miss_resize_ctrl;
  localparam int CNT_W = 4;
  localparam int THR   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l2 = 1'b0;
  logic [CNT_W-1:0] cnt = '0;
  logic fp = 1'b0;
  logic [3:0] done = 4'h0;
  logic [1:0] issue_m, rob_m, irf_m, frf_m;
  logic restore;

  int total = 0;
  int bad = 0;
  string tag = "R1";

  always #5 clk = ~clk;

  miss_resize_ctrl #(.CNT_W(CNT_W), .L1_THRESH(THR)) dut (
    .clk(clk), .rst_n(rst_n), .l2_miss_i(l2), .l1_miss_cnt_i(cnt),
    .fp_class_i(fp), .done_i(done), .issue_mode_o(issue_m), .rob_mode_o(rob_m),
    .irf_mode_o(irf_m), .frf_mode_o(frf_m), .restore_req_o(restore)
  );

  // Reference model: 0 idle, 1 second-level stall, 2 first-level stall, 3 restore
  logic m_l2 = 1'b0, m_fp = 1'b0;
  logic [CNT_W-1:0] m_cnt = '0;
  int m_st = 0;
  logic [3:0] m_seen = 4'h0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_l2 <= 1'b0; m_cnt <= '0; m_fp <= 1'b0; m_st <= 0; m_seen <= 4'h0;
    end else begin
      m_l2 <= l2; m_cnt <= cnt; m_fp <= fp;
      m_seen <= (m_st == 3) ? (m_seen | done) : 4'h0;
      case (m_st)
        0: if (m_l2) m_st <= 1; else if (int'(m_cnt) >= THR) m_st <= 2;
        1: if (!m_l2) m_st <= (int'(m_cnt) >= THR) ? 2 : 3;
        2: if (m_l2) m_st <= 1; else if (int'(m_cnt) < THR) m_st <= 3;
        default: if ((m_seen | done) == 4'hF) m_st <= 0;
      endcase
    end
  end

  function automatic logic [1:0] exp_issue(int st);
    return (st == 1) ? 2'b01 : 2'b00;
  endfunction
  function automatic logic [1:0] exp_rob(int st);
    return (st == 1 || st == 2) ? 2'b10 : 2'b00;
  endfunction
  function automatic logic [1:0] exp_rf(int st, logic active);
    return active ? exp_rob(st) : 2'b01;
  endfunction

  task automatic chk(string req, string what, logic [1:0] act, logic [1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s/%s %s: got %b expected %b at %0t", req, tag, what, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R2", "issue", issue_m, exp_issue(m_st));
    chk("R3", "rob", rob_m, exp_rob(m_st));
    chk(m_fp ? "R5" : "R6", "irf", irf_m, exp_rf(m_st, !m_fp));
    chk(m_fp ? "R6" : "R5", "frf", frf_m, exp_rf(m_st, m_fp));
    chk("R7", "restore", {1'b0, restore}, {1'b0, m_st == 3});
    chk("R9", "code", {1'b0, (issue_m == 2'b11) || (rob_m == 2'b11) ||
                             (irf_m == 2'b11) || (frf_m == 2'b11)}, 2'b00);
  endtask

  task automatic step(logic a_l2, int a_cnt, logic a_fp, logic [3:0] a_done);
    @(negedge clk);
    check_all();
    l2 = a_l2; cnt = CNT_W'(a_cnt); fp = a_fp; done = a_done;
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    // R1: reset values
    tag = "R1";
    repeat (3) step(1'b0, 0, 1'b0, 4'h0);
    @(negedge clk);
    chk("R1", "issue_rst", issue_m, 2'b00);
    chk("R1", "frf_rst", frf_m, 2'b01);
    rst_n = 1'b1;
    step(1'b0, 0, 1'b0, 4'h0);
    chk("R1", "restore_rst", {1'b0, restore}, 2'b00);

    // R3: threshold boundary, 2 then 3
    tag = "R3";
    repeat (4) step(1'b0, THR - 1, 1'b0, 4'h0);
    chk("R3", "below_thr", rob_m, 2'b00);
    repeat (3) step(1'b0, THR, 1'b0, 4'h0);
    chk("R3", "at_thr_rob", rob_m, 2'b10);
    chk("R3", "at_thr_issue", issue_m, 2'b00);
    chk("R6", "int_rf_grow", irf_m, 2'b10);

    // R4: both triggers
    tag = "R4";
    repeat (3) step(1'b1, 5, 1'b0, 4'h0);
    chk("R4", "both_issue", issue_m, 2'b01);
    chk("R4", "both_rob", rob_m, 2'b10);

    // R7/R8: restore with staggered acks and an ignored miss
    tag = "R8";
    repeat (3) step(1'b0, 0, 1'b1, 4'h0);
    chk("R7", "restore_up", {1'b0, restore}, 2'b01);
    step(1'b0, 0, 1'b1, 4'h1);
    step(1'b1, 0, 1'b1, 4'h2);
    step(1'b1, 0, 1'b1, 4'h4);
    step(1'b1, 0, 1'b1, 4'h0);
    chk("R8", "still_restore", {1'b0, restore}, 2'b01);
    chk("R5", "fp_irf_half", irf_m, 2'b01);
    step(1'b0, 0, 1'b1, 4'h8);
    step(1'b0, 0, 1'b1, 4'h0);
    chk("R8", "restore_done", {1'b0, restore}, 2'b00);
    repeat (3) step(1'b0, 0, 1'b1, 4'hF);
    chk("R8", "done_outside", {1'b0, restore}, 2'b00);

    // Random traffic
    tag = "RND";
    for (int i = 0; i < 4000; i++) begin
      logic nl2, nfp;
      logic [3:0] nd;
      nl2 = (($urandom % 16) == 0) ? ~l2 : l2;
      nfp = (($urandom % 64) == 0) ? ~fp : fp;
      for (int b = 0; b < 4; b++) nd[b] = (($urandom % 4) == 0);
      step(nl2, int'($urandom % 6), nfp, nd);
    end
    step(1'b0, 0, 1'b0, 4'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule